// File: doc/BRIEF.md
# AES Round-Key Assist Datapath

This block performs the per-step word transformation at the heart of AES-128 key expansion. A 128-bit source is viewed as four 32-bit lanes. The two odd lanes each pass through byte-wise forward S-box substitution. Each substituted word is placed in the result twice: once as it is, and once rotated by one byte and XORed with a round constant. The round constant is an 8-bit input widened with zeros. The result is registered, so it appears one clock after the request.

The block also produces a 256-bit destination image. The lower half holds the computed result. The upper half depends on a mode input. In legacy mode it copies the caller's previous upper contents. In extended mode it is cleared to zero. An extended-mode request must carry a 4-bit reserved field equal to all ones. Any other value rejects the request: the block raises a one-cycle illegal flag and leaves the destination unchanged. The S-box is computed in logic as a GF(2^8) inverse followed by the affine map, so the block needs no table storage.

Top module: `keyexp_assist`

## Requirements
- R1: A request with in_valid high is answered exactly one clock later. If the request is accepted, out_valid goes high; if it is rejected, illegal goes high. In any cycle after a cycle without in_valid, both out_valid and illegal are low.
- R2: The source is split into lanes X0 = src[31:0], X1 = src[63:32], X2 = src[95:64] and X3 = src[127:96]. The round constant word is {24'h0, imm}.
- R3: On an accepted request, dest[31:0] = SubWord(X1) and dest[63:32] = RotWord(SubWord(X1)) XOR constant, where RotWord(w) = {w[7:0], w[31:8]}.
- R4: On an accepted request, dest[95:64] = SubWord(X3) and dest[127:96] = RotWord(SubWord(X3)) XOR constant.
- R5: Lanes X0 and X2 have no effect on any output.
- R6: With mode = 0 (legacy), the request is accepted whatever rsvd holds, and dest[255:128] takes the value dest_in had at the request.
- R7: With mode = 1 (extended) and rsvd = 4'b1111, the request is accepted and dest[255:128] becomes zero.
- R8: With mode = 1 and rsvd other than 4'b1111, illegal is high for one cycle, out_valid stays low and dest keeps its previous value.
- R9: While rst_n is low at a rising clock edge, out_valid, illegal and the whole of dest are cleared to zero.
- R10: SubWord applies the standard AES forward S-box to each byte on its own. For example, S(0x00) = 0x63, S(0x09) = 0x01, S(0xCF) = 0x8A, S(0x4F) = 0x84 and S(0x3C) = 0xEB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src | input | 128 | Source word, four 32-bit lanes |
| imm | input | 8 | Round constant byte |
| mode | input | 1 | 0 = legacy (keep upper half), 1 = extended (clear upper half) |
| rsvd | input | 4 | Reserved field; must be 4'b1111 in extended mode |
| dest_in | input | 128 | Previous upper-half contents of the destination (bits 255:128) |
| out_valid | output | 1 | Result registered this cycle |
| dest | output | 256 | Destination image |
| illegal | output | 1 | Rejected extended-mode request |

## Verification
The bench checks the first step of the standard AES-128 key expansion vector. Here a byte-order or rotation-direction error shows up directly as a wrong top lane. It also checks an all-zero source, where a missing affine constant would give zero bytes instead of 0x63. It repeats requests that share the odd lanes but differ in the even lanes, which catches a design that picks the wrong lane pair. It drives an extended request with a bad reserved field after a good result. A design that wrote on rejection would corrupt the held destination, and one that ignored the reserved field would never raise the flag. A legacy request with a zero reserved field must still be accepted.

// File: rtl/keyexp_pkg.sv
package keyexp_pkg;

  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_EXT    = 1'b1
  } dest_mode_e;

  // GF(2^8) product modulo x^8 + x^4 + x^3 + x + 1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // inverse as a^254 (zero maps to zero), MSB-first square and multiply
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] e;
    r = 8'h01;
    e = 8'd254;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (e[i]) r = gf_mul(r, a);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] rot_word(input logic [31:0] w);
    return {w[7:0], w[31:8]};
  endfunction

endpackage

// File: rtl/keyexp_subword.sv
module keyexp_subword #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] word_in,
  output logic [LANE_W-1:0] word_out
);
  import keyexp_pkg::*;

  localparam int NBYTES = LANE_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign word_out[b*8 +: 8] = sbox_fwd(word_in[b*8 +: 8]);
  end

endmodule

// File: rtl/keyexp_lane.sv
module keyexp_lane #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0]   word_in,
  input  logic [LANE_W-1:0]   rcon,
  output logic [2*LANE_W-1:0] pair_out
);

  logic [LANE_W-1:0] sub_w;
  logic [LANE_W-1:0] rot_w;

  keyexp_subword #(.LANE_W(LANE_W)) u_sub (
    .word_in (word_in),
    .word_out(sub_w)
  );

  assign rot_w    = {sub_w[7:0], sub_w[LANE_W-1:8]};
  assign pair_out = {rot_w ^ rcon, sub_w};

endmodule

// File: rtl/keyexp_assist.sv
module keyexp_assist #(
  parameter int LANE_W    = 32,
  parameter int NUM_LANES = 4,
  parameter int IMM_W     = 8,
  parameter int RSVD_W    = 4,
  parameter int DEST_W    = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [LANE_W*NUM_LANES-1:0] src,
  input  logic [IMM_W-1:0]            imm,
  input  logic                        mode,
  input  logic [RSVD_W-1:0]           rsvd,
  input  logic [DEST_W-1:LANE_W*NUM_LANES] dest_in,
  output logic                        out_valid,
  output logic [DEST_W-1:0]           dest,
  output logic                        illegal
);
  import keyexp_pkg::*;

  localparam int SRC_W = LANE_W * NUM_LANES;
  localparam int PAIRS = NUM_LANES / 2;

  logic [LANE_W-1:0]         rcon_w;
  logic [SRC_W-1:0]          low_next;
  logic [DEST_W-1:SRC_W]     upper_next;
  logic                      ext_req;
  logic                      rsvd_ok;
  logic                      req_bad;
  logic                      req_ok;
  logic [LANE_W-1:0]         rcon_q;

  assign rcon_w  = {{(LANE_W-IMM_W){1'b0}}, imm};
  assign ext_req = (mode == MODE_EXT);
  assign rsvd_ok = (rsvd == {RSVD_W{1'b1}});
  assign req_bad = in_valid && ext_req && !rsvd_ok;
  assign req_ok  = in_valid && !req_bad;

  // odd lanes feed the result; each yields a (plain, rotated^rcon) pair
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    keyexp_lane #(.LANE_W(LANE_W)) u_lane (
      .word_in (src[(2*p+1)*LANE_W +: LANE_W]),
      .rcon    (rcon_w),
      .pair_out(low_next[p*2*LANE_W +: 2*LANE_W])
    );
  end

  assign upper_next = ext_req ? '0 : dest_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      dest      <= '0;
      rcon_q    <= '0;
    end else begin
      out_valid <= req_ok;
      illegal   <= req_bad;
      if (req_ok) begin
        dest   <= {upper_next, low_next};
        rcon_q <= rcon_w;
      end
    end
  end

  // ---------------- assertions ----------------

  // R2
  src_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !$isunknown({src, imm, mode, rsvd, dest_in}));

  // R1
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == MODE_LEGACY || rsvd == {RSVD_W{1'b1}})) |=> (out_valid && !illegal));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !illegal));

  // R8
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_EXT && rsvd != {RSVD_W{1'b1}}) |=> (illegal && !out_valid));

  // R8
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(dest));

  // R7
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_EXT) |=> (illegal || dest[DEST_W-1:SRC_W] == '0));

  // R6
  legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_LEGACY) |=> (dest[DEST_W-1:SRC_W] == $past(dest_in)));

  // R3 R4
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair_chk
    lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (dest[(2*p+1)*LANE_W +: LANE_W] ==
        ({dest[2*p*LANE_W +: 8], dest[2*p*LANE_W+8 +: LANE_W-8]} ^ rcon_q)));
  end

endmodule

// File: tb/test_keyexp_assist.sv
module test_keyexp_assist;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src;
  logic [7:0]   imm;
  logic         mode;
  logic [3:0]   rsvd;
  logic [255:128] dest_in;
  logic         out_valid;
  logic [255:0] dest;
  logic         illegal;

  int n_checks = 0;
  int n_fails  = 0;
  logic [255:0] exp_dest;

  always #2 clk = ~clk;

  keyexp_assist i_keyexp_assist (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .imm(imm),
    .mode(mode), .rsvd(rsvd), .dest_in(dest_in), .out_valid(out_valid),
    .dest(dest), .illegal(illegal)
  );

  // ---- behavioural reference ----
  function automatic int m_mul(int a, int b);
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) r = r ^ a;
      a = a << 1;
      if (a & 256) a = a ^ 283;
    end
    return r & 255;
  endfunction

  function automatic int m_sbox(int a);
    int inv = 0;
    int s;
    for (int c = 1; c < 256; c++) if (m_mul(a, c) == 1) inv = c;
    s = inv;
    for (int k = 1; k <= 4; k++) s = s ^ (((inv << k) | (inv >> (8 - k))) & 255);
    return s ^ 99;
  endfunction

  function automatic logic [31:0] m_sub(logic [31:0] w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'(m_sbox(int'(w[k*8 +: 8])));
    return r;
  endfunction

  function automatic logic [31:0] m_rot(logic [31:0] w);
    return (w >> 8) | (w << 24);
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // drive one request, compute expectation, sample at the following negedge
  task automatic run_op(logic [127:0] s, logic [7:0] i, logic m, logic [3:0] r,
                        logic [255:128] di, string tag);
    logic bad;
    logic [31:0] a, b;
    @(negedge clk);
    src = s; imm = i; mode = m; rsvd = r; dest_in = di; in_valid = 1'b1;
    bad = m && (r != 4'hF);
    if (!bad) begin
      a = m_sub(s[63:32]);
      b = m_sub(s[127:96]);
      exp_dest[31:0]    = a;
      exp_dest[63:32]   = m_rot(a) ^ {24'h0, i};
      exp_dest[95:64]   = b;
      exp_dest[127:96]  = m_rot(b) ^ {24'h0, i};
      exp_dest[255:128] = m ? 128'h0 : di;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R1 out_valid"}, {255'h0, out_valid}, {255'h0, !bad});
    chk({tag, " R8 illegal"},   {255'h0, illegal},   {255'h0, bad});
    chk({tag, " R3 lanes01"},   {192'h0, dest[63:0]},    {192'h0, exp_dest[63:0]});
    chk({tag, " R4 lanes23"},   {192'h0, dest[127:64]},  {192'h0, exp_dest[127:64]});
    chk({tag, " R6/R7 upper"},  {128'h0, dest[255:128]}, {128'h0, exp_dest[255:128]});
  endtask

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [255:0] saved;
    rst_n = 1'b0; in_valid = 1'b1; src = '1; imm = 8'hff; mode = 1'b0;
    rsvd = 4'h0; dest_in = '1;
    exp_dest = '0;
    repeat (3) @(negedge clk);
    // R9 reset clears everything even with a request pending
    chk("R9 out_valid", {255'h0, out_valid}, 256'h0);
    chk("R9 illegal",   {255'h0, illegal},   256'h0);
    chk("R9 dest",      dest,                256'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R10 zero source: every substituted byte is 0x63
    run_op(128'h0, 8'h5a, 1'b0, 4'h0, {4{32'hdeadbeef}}, "zero");
    chk("R10 S(00)", {224'h0, dest[31:0]}, {224'h0, 32'h63636363});
    chk("R3 rcon xor", {224'h0, dest[63:32]}, {224'h0, 32'h63636339});

    // key expansion vector, first step: w3 = 09cf4f3c in byte order
    run_op({32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b}, 8'h01,
           1'b0, 4'hF, 128'h0, "fips");
    chk("R10 R4 SubWord(w3)", {224'h0, dest[95:64]},  {224'h0, 32'heb848a01});
    chk("R4 rot^rcon(w3)",    {224'h0, dest[127:96]}, {224'h0, 32'h01eb848b});
    saved = dest;

    // R5 same odd lanes, different even lanes
    run_op({32'h3c4fcf09, 32'h12345678, 32'ha6d2ae28, 32'h9abcdef0}, 8'h01,
           1'b0, 4'hF, 128'h0, "even");
    chk("R5 even lanes ignored", dest, saved);

    // R7 extended legal clears the upper half
    run_op({4{32'hc0ffee11}}, 8'h36, 1'b1, 4'hF, {4{32'hffffffff}}, "ext");
    chk("R7 upper zero", {128'h0, dest[255:128]}, 256'h0);
    saved = dest;

    // R8 rejected request leaves dest untouched
    run_op({4{32'h0badf00d}}, 8'h1b, 1'b1, 4'h7, {4{32'h55aa55aa}}, "bad");
    chk("R8 dest held", dest, saved);
    run_op({4{32'h01020304}}, 8'h80, 1'b1, 4'h0, {4{32'h11111111}}, "bad0");
    chk("R8 dest held again", dest, saved);

    // R6 legacy accepts any reserved value
    run_op({4{32'h76543210}}, 8'h02, 1'b0, 4'h3, {4{32'h24681357}}, "leg");

    // R1 idle cycle: no strobes, dest held
    saved = dest;
    @(negedge clk);
    chk("R1 idle out_valid", {255'h0, out_valid}, 256'h0);
    chk("R1 idle illegal",   {255'h0, illegal},   256'h0);
    chk("R1 idle dest",      dest,                saved);

    // random mix
    for (int n = 0; n < 60; n++) begin
      run_op({$urandom, $urandom, $urandom, $urandom}, 8'($urandom),
             1'($urandom), 4'($urandom_range(0, 3) == 0 ? 4'hF : 4'($urandom)),
             {$urandom, $urandom, $urandom, $urandom}, "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule